// File: doc/BRIEF.md
# Indexed Real-Time Clock Core

This block keeps calendar time (seconds, minutes, hours, weekday, date, month and two-digit year). A host reaches it through a narrow indexed register window. The host first loads an index through the pointer strobe. It then writes a data byte through the data strobe, or reads the byte shown on `dout`.

An external one-second tick starts a short update window of fixed length. During that window a read-only busy flag is visible to the host. At the end of the window the whole time chain advances once, with carries rippling from seconds up to the year. Each completed update latches an update-ended flag. An alarm flag is latched when the new seconds, minutes and hours equal the three alarm registers. Enabled flags are gathered into a summary bit, which also drives the active-high `irq` pin. Reading the status register clears every flag.

A hold bit in the second control register freezes counting while the host loads a new time. The register window also includes a bank of general storage bytes. Only binary values and 24-hour hours are supported.

Top module: `rtc_indexed`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0; weekday, date and month read 1; alarms, both control registers, the status register and all storage bytes read 0; `irq` is low.
- R2: Index map: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday, 7 date, 8 month, 9 year, 10 control A, 11 control B, 12 status C, 13 status D, 14 and up storage bytes. Time, alarm, control B and storage bytes read back what was written.
- R3: A tick with hold clear makes control A bit 7 read 1 for UIP_CYCLES cycles, after which seconds advance by exactly one. Further ticks that arrive inside the window are ignored.
- R4: Rollover limits: seconds and minutes wrap 59 to 0, hours wrap 23 to 0, weekday wraps 7 to 1, date wraps past month length to 1, month wraps 12 to 1, and year wraps 99 to 0. Each wrap carries one into the next field, and weekday advances with the date.
- R5: Month length is 31 for months 1, 3, 5, 7, 8, 10, 12 and 30 for months 4, 6, 9, 11. February has 28 days, or 29 when LEAP_EN is set and the year is a multiple of 4.
- R6: While control B bit 7 (hold) is 1, ticks do not change the time. After the host clears it, ticks advance the time again.
- R7: Control A bit 7 is read-only busy; a host write does not affect it. Bits 6..0 read back what was written.
- R8: Each completed update sets status C bit 4. It also sets status C bit 5 when the new seconds, minutes and hours all equal the alarm registers. Flags are set regardless of the enables.
- R9: Status C bit 7 is 1 exactly when (bit 5 and control B bit 5) or (bit 4 and control B bit 4). `irq` equals status C bit 7.
- R10: A data read of status C returns its current value, then clears bits 7, 5 and 4 and drops `irq`.
- R11: Status D always reads 0x80. Host writes to status C and status D have no effect.
- R12: Writing control B bits 2 and 1 (data-mode bits) leaves the stored time and alarm values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second tick, one cycle wide |
| idx_wr | input | 1 | Load the register index from `din` |
| dat_wr | input | 1 | Write `din` to the indexed register |
| dat_rd | input | 1 | Data read strobe (clears flags at status C) |
| din | input | 8 | Index or data byte from the host |
| dout | output | 8 | Contents of the indexed register |
| irq | output | 1 | Active-high interrupt, equals status C bit 7 |

## Verification
The bench uses the default parameters. IDX_W = 6 and NV_BYTES = 50 make the storage bank end exactly at index 63, so the last reachable byte is tested. UIP_CYCLES = 4 keeps the busy window long enough that a read issued right after a tick sees bit 7 set, and a second tick can land inside the window. LEAP_EN = 1 lets a February in a year divisible by 4 be compared against a common year. Random times, alarms and enables, drawn with a fixed seed, are mixed with directed carries through every field up to the year wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic [7:0] dow;
      logic [7:0] dom;
      logic [7:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   // register window layout
   localparam int IX_SEC   = 0;
   localparam int IX_ASEC  = 1;
   localparam int IX_MIN   = 2;
   localparam int IX_AMIN  = 3;
   localparam int IX_HOUR  = 4;
   localparam int IX_AHOUR = 5;
   localparam int IX_DOW   = 6;
   localparam int IX_DOM   = 7;
   localparam int IX_MON   = 8;
   localparam int IX_YEAR  = 9;
   localparam int IX_CTLA  = 10;
   localparam int IX_CTLB  = 11;
   localparam int IX_STC   = 12;
   localparam int IX_STD   = 13;
   localparam int IX_STORE = 14;

   // bit positions
   localparam int B_HOLD = 7;
   localparam int B_AIE  = 5;
   localparam int B_UIE  = 4;

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
      case (mon)
         8'd2:                       month_days = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:    month_days = 8'd30;
         default:                    month_days = 8'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
   parameter int UIP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic uip,
   output logic commit
);
   localparam int CW = $clog2(UIP_CYCLES + 1);

   if (UIP_CYCLES < 1) begin : g_bad_len
      $error("UIP_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == '0) begin
         if (tick && !hold) cnt_q <= CW'(UIP_CYCLES);
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign uip    = (cnt_q != '0);
   assign commit = (cnt_q == CW'(1)) && !hold;

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       wr_en,
   input  logic [3:0] wr_idx,
   input  logic [7:0] wr_val,
   output rtc_time_t  cur,
   output rtc_time_t  nxt
);
   logic       leap;
   logic [7:0] dim;

   if (LEAP_EN) begin : g_leap
      assign leap = (cur.year[1:0] == 2'b00);
   end else begin : g_noleap
      assign leap = 1'b0;
   end

   assign dim = month_days(cur.mon, leap);

   always_comb begin
      nxt = cur;
      if (cur.sec >= 8'd59) begin
         nxt.sec = 8'd0;
         if (cur.min >= 8'd59) begin
            nxt.min = 8'd0;
            if (cur.hour >= 8'd23) begin
               nxt.hour = 8'd0;
               nxt.dow  = (cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1;
               if (cur.dom >= dim) begin
                  nxt.dom = 8'd1;
                  if (cur.mon >= 8'd12) begin
                     nxt.mon  = 8'd1;
                     nxt.year = (cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1;
                  end else begin
                     nxt.mon = cur.mon + 8'd1;
                  end
               end else begin
                  nxt.dom = cur.dom + 8'd1;
               end
            end else begin
               nxt.hour = cur.hour + 8'd1;
            end
         end else begin
            nxt.min = cur.min + 8'd1;
         end
      end else begin
         nxt.sec = cur.sec + 8'd1;
      end
   end

   // host write lands after the advance so the host wins on a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur.sec  <= 8'd0;
         cur.min  <= 8'd0;
         cur.hour <= 8'd0;
         cur.dow  <= 8'd1;
         cur.dom  <= 8'd1;
         cur.mon  <= 8'd1;
         cur.year <= 8'd0;
      end else begin
         if (adv) cur <= nxt;
         if (wr_en) begin
            case (wr_idx)
               4'(IX_SEC):  cur.sec  <= wr_val;
               4'(IX_MIN):  cur.min  <= wr_val;
               4'(IX_HOUR): cur.hour <= wr_val;
               4'(IX_DOW):  cur.dow  <= wr_val;
               4'(IX_DOM):  cur.dom  <= wr_val;
               4'(IX_MON):  cur.mon  <= wr_val;
               4'(IX_YEAR): cur.year <= wr_val;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
   parameter int DEPTH = 50,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wd,
   output logic [7:0]    rd
);
   if (DEPTH > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for DEPTH");
   end

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'd0;
      end else if (we && (int'(addr) < DEPTH)) begin
         mem_q[addr] <= wd;
      end
   end

   assign rd = (int'(addr) < DEPTH) ? mem_q[addr] : 8'd0;

endmodule

// File: rtl/rtc_indexed.sv
module rtc_indexed
   import rtc_pkg::*;
#(
   parameter int IDX_W      = 6,
   parameter int NV_BYTES   = 50,
   parameter int UIP_CYCLES = 4,
   parameter bit LEAP_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic       dat_rd,
   input  logic [7:0] din,
   output logic [7:0] dout,
   output logic       irq
);
   localparam int NV_AW = (NV_BYTES > 1) ? $clog2(NV_BYTES) : 1;

   if (IDX_W > 8 || IX_STORE + NV_BYTES > (1 << IDX_W)) begin : g_bad_map
      $error("register window does not fit IDX_W");
   end
   if (NV_BYTES < 1) begin : g_bad_nv
      $error("NV_BYTES must be at least 1");
   end

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       alm_s, alm_m, alm_h, ctlb;
   logic [6:0]       ctla_lo;
   logic             af, uf, uip, commit, summary, in_store, time_wr, rd_c, match;
   logic [7:0]       stat_c, st_rd;
   rtc_time_t        t_cur, t_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else if (idx_wr) idx_q <= din[IDX_W-1:0];
   end

   assign in_store = (int'(idx_q) >= IX_STORE) && (int'(idx_q) < IX_STORE + NV_BYTES);

   always_comb begin
      case (int'(idx_q))
         IX_SEC, IX_MIN, IX_HOUR, IX_DOW, IX_DOM, IX_MON, IX_YEAR: time_wr = dat_wr;
         default: time_wr = 1'b0;
      endcase
   end

   rtc_update_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold(ctlb[B_HOLD]),
      .uip(uip), .commit(commit)
   );

   rtc_time_chain #(.LEAP_EN(LEAP_EN)) u_chain (
      .clk(clk), .rst_n(rst_n), .adv(commit), .wr_en(time_wr),
      .wr_idx(idx_q[3:0]), .wr_val(din), .cur(t_cur), .nxt(t_nxt)
   );

   rtc_store #(.DEPTH(NV_BYTES), .AW(NV_AW)) u_store (
      .clk(clk), .rst_n(rst_n), .we(dat_wr && in_store),
      .addr(NV_AW'(idx_q - IDX_W'(IX_STORE))), .wd(din), .rd(st_rd)
   );

   // control and alarm registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_s   <= 8'd0;
         alm_m   <= 8'd0;
         alm_h   <= 8'd0;
         ctla_lo <= 7'd0;
         ctlb    <= 8'd0;
      end else if (dat_wr) begin
         case (int'(idx_q))
            IX_ASEC:  alm_s   <= din;
            IX_AMIN:  alm_m   <= din;
            IX_AHOUR: alm_h   <= din;
            IX_CTLA:  ctla_lo <= din[6:0];
            IX_CTLB:  ctlb    <= din;
            default: ;
         endcase
      end
   end

   // flags: a new event wins over a clearing read in the same cycle
   assign match = (t_nxt.sec == alm_s) && (t_nxt.min == alm_m) && (t_nxt.hour == alm_h);
   assign rd_c  = dat_rd && (int'(idx_q) == IX_STC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         af <= 1'b0;
         uf <= 1'b0;
      end else begin
         if (commit) uf <= 1'b1;
         else if (rd_c) uf <= 1'b0;
         if (commit && match) af <= 1'b1;
         else if (rd_c) af <= 1'b0;
      end
   end

   assign summary = (af && ctlb[B_AIE]) || (uf && ctlb[B_UIE]);
   assign stat_c  = {summary, 1'b0, af, uf, 4'b0000};
   assign irq     = summary;

   always_comb begin
      if (in_store) begin
         dout = st_rd;
      end else begin
         case (int'(idx_q))
            IX_SEC:   dout = t_cur.sec;
            IX_ASEC:  dout = alm_s;
            IX_MIN:   dout = t_cur.min;
            IX_AMIN:  dout = alm_m;
            IX_HOUR:  dout = t_cur.hour;
            IX_AHOUR: dout = alm_h;
            IX_DOW:   dout = t_cur.dow;
            IX_DOM:   dout = t_cur.dom;
            IX_MON:   dout = t_cur.mon;
            IX_YEAR:  dout = t_cur.year;
            IX_CTLA:  dout = {uip, ctla_lo};
            IX_CTLB:  dout = ctlb;
            IX_STC:   dout = stat_c;
            IX_STD:   dout = 8'h80;
            default:  dout = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/rtc_indexed_chk.sv
module rtc_indexed_chk #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dat_wr,
   input logic             dat_rd,
   input logic [IDX_W-1:0] idx_q,
   input logic [7:0]       dout,
   input logic             irq,
   input logic             uip,
   input logic             commit,
   input logic [7:0]       ctlb,
   input logic             af,
   input logic             uf,
   input logic [7:0]       sec
);
   a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (ctlb[7] && !(dat_wr && idx_q == IDX_W'(0))) |=> $stable(sec));

   a_r3_change_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!(dat_wr && idx_q == IDX_W'(0)) && !uip) |=> $stable(sec));

   a_r7_busy_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == IDX_W'(10)) |-> (dout[7] == uip));

   a_r8_update_flag: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> uf);

   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((af && ctlb[5]) || (uf && ctlb[4])));

   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && idx_q == IDX_W'(12) && !commit) |=> (!irq && !af && !uf));

   a_r11_status_d: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == IDX_W'(13)) |-> (dout == 8'h80));

endmodule

bind rtc_indexed rtc_indexed_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_rd(dat_rd), .idx_q(idx_q),
   .dout(dout), .irq(irq), .uip(uip), .commit(commit), .ctlb(ctlb),
   .af(af), .uf(uf), .sec(t_cur.sec)
);

// File: tb/rtc_indexed_bench.sv
`timescale 1ns/1ps
module rtc_indexed_bench;
   localparam int UIPC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
   logic [7:0] din = 8'd0;
   logic [7:0] dout;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int tm [7];   // sec, min, hour, dow, dom, mon, year
   int fidx [7] = '{0, 2, 4, 6, 7, 8, 9};
   string fname [7] = '{"sec", "min", "hour", "dow", "dom", "mon", "year"};

   always #2.5 clk = ~clk;

   rtc_indexed u_rtc_indexed (
      .clk(clk), .rst_n(rst_n), .tick(tick), .idx_wr(idx_wr), .dat_wr(dat_wr),
      .dat_rd(dat_rd), .din(din), .dout(dout), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks enter and leave at a falling edge
   task automatic wr(input int ix, input int v);
      idx_wr = 1'b1; din = 8'(ix);
      @(negedge clk);
      idx_wr = 1'b0; dat_wr = 1'b1; din = 8'(v);
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   task automatic rd(input int ix, output int v);
      idx_wr = 1'b1; din = 8'(ix);
      @(negedge clk);
      idx_wr = 1'b0;
      v = int'(dout);
   endtask

   task automatic rd_clr(output int v);
      rd(12, v);
      dat_rd = 1'b1;
      @(negedge clk);
      dat_rd = 1'b0;
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic settle();
      repeat (UIPC + 2) @(negedge clk);
   endtask

   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic void step_model();
      if (tm[0] < 59) begin tm[0]++; return; end
      tm[0] = 0;
      if (tm[1] < 59) begin tm[1]++; return; end
      tm[1] = 0;
      if (tm[2] < 23) begin tm[2]++; return; end
      tm[2] = 0;
      tm[3] = (tm[3] >= 7) ? 1 : tm[3] + 1;
      if (tm[4] < mdays(tm[5], tm[6])) begin tm[4]++; return; end
      tm[4] = 1;
      if (tm[5] < 12) begin tm[5]++; return; end
      tm[5] = 1;
      tm[6] = (tm[6] >= 99) ? 0 : tm[6] + 1;
   endfunction

   task automatic load_time(input int s, input int mi, input int h, input int dw,
                            input int dm, input int mo, input int y);
      tm = '{s, mi, h, dw, dm, mo, y};
      for (int i = 0; i < 7; i++) wr(fidx[i], tm[i]);
   endtask

   task automatic cmp_time(input string req);
      int v;
      for (int i = 0; i < 7; i++) begin
         rd(fidx[i], v);
         chk($sformatf("%s %s", req, fname[i]), v, tm[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      tm = '{0, 0, 0, 1, 1, 1, 0};
      cmp_time("R1");
      rd(1, v);  chk("R1 alarm sec", v, 0);
      rd(10, v); chk("R1 ctl A", v, 0);
      rd(11, v); chk("R1 ctl B", v, 0);
      rd(12, v); chk("R1 status C", v, 0);
      rd(40, v); chk("R1 storage", v, 0);

      // R2 register map read back
      wr(1, 17); wr(3, 42); wr(5, 9);
      rd(1, v); chk("R2 alarm sec", v, 17);
      rd(3, v); chk("R2 alarm min", v, 42);
      rd(5, v); chk("R2 alarm hour", v, 9);
      wr(14, 8'hA5); wr(40, 8'h3C); wr(63, 8'h5A);
      rd(14, v); chk("R2 storage first", v, 8'hA5);
      rd(40, v); chk("R2 storage mid", v, 8'h3C);
      rd(63, v); chk("R2 storage last", v, 8'h5A);
      wr(11, 8'h02); rd(11, v); chk("R2 ctl B", v, 8'h02);

      // R7 busy bit not writable
      wr(10, 8'hFF); rd(10, v); chk("R7 ctl A write", v, 8'h7F);

      // R11 status registers ignore writes
      wr(12, 8'hFF); rd(12, v); chk("R11 status C write", v, 0);
      wr(13, 8'h00); rd(13, v); chk("R11 status D", v, 8'h80);

      // R12 mode bits do not rewrite time
      load_time(33, 44, 15, 3, 20, 6, 50);
      wr(11, 8'h06); wr(11, 8'h00); wr(11, 8'h04);
      cmp_time("R12");
      rd(3, v); chk("R12 alarm min", v, 42);
      wr(11, 8'h00);

      // R3 busy window and tick inside window ignored
      load_time(10, 0, 0, 1, 1, 1, 0);
      rd_clr(v);
      pulse_tick();
      rd(10, v); chk("R3 busy visible", (v >> 7) & 1, 1);
      pulse_tick();
      settle();
      rd(10, v); chk("R3 busy cleared", (v >> 7) & 1, 0);
      step_model();
      cmp_time("R3");

      // R6 hold freezes counting
      wr(11, 8'h80);
      pulse_tick(); settle();
      cmp_time("R6 held");
      wr(11, 8'h00);
      pulse_tick(); settle();
      step_model();
      cmp_time("R6 resumed");

      // R4 full carry with year wrap
      load_time(59, 59, 23, 7, 31, 12, 99);
      pulse_tick(); settle(); step_model();
      cmp_time("R4 year wrap");
      chk("R4 weekday wrap", tm[3], 1);

      // R5 month lengths
      load_time(59, 59, 23, 2, 28, 2, 1);
      pulse_tick(); settle(); step_model();
      cmp_time("R5 feb common");
      load_time(59, 59, 23, 2, 28, 2, 4);
      pulse_tick(); settle(); step_model();
      cmp_time("R5 feb leap");
      load_time(59, 59, 23, 5, 30, 4, 7);
      pulse_tick(); settle(); step_model();
      cmp_time("R5 thirty day");
      load_time(59, 59, 23, 5, 30, 7, 7);
      pulse_tick(); settle(); step_model();
      cmp_time("R5 thirty-one day");

      // R8 R9 R10 random trials
      rd_clr(v);
      for (int t = 0; t < 40; t++) begin
         int s, mi, h, dw, mo, y, dm, en, as, am, ah, match, expc, ex_irq;
         s  = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
         mi = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
         h  = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
         dw = 1 + int'($urandom % 7);
         mo = 1 + int'($urandom % 12);
         y  = int'($urandom % 100);
         dm = ($urandom % 2 == 0) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
         load_time(s, mi, h, dw, dm, mo, y);
         step_model();
         if ($urandom % 2 == 0) begin
            as = tm[0]; am = tm[1]; ah = tm[2];
         end else begin
            as = int'($urandom % 60); am = tm[1]; ah = int'($urandom % 24);
         end
         wr(1, as); wr(3, am); wr(5, ah);
         en = int'($urandom % 4);
         wr(11, (en & 2) ? 8'h20 | ((en & 1) ? 8'h10 : 0) : ((en & 1) ? 8'h10 : 0));
         pulse_tick(); settle();
         match  = (as == tm[0] && am == tm[1] && ah == tm[2]) ? 1 : 0;
         ex_irq = ((match && (en & 2)) || (en & 1)) ? 1 : 0;
         expc   = (ex_irq << 7) | (match << 5) | (1 << 4);
         chk("R9 irq pin", int'(irq), ex_irq);
         rd_clr(v);
         chk("R8 status C", v, expc);
         chk("R10 irq after read", int'(irq), 0);
         rd(12, v); chk("R10 status cleared", v, 0);
         cmp_time("R4 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule